// File: doc/BRIEF.md
# Path and Line Status Byte Monitor

This block watches two byte-interleaved STS-12 style streams for the status bytes a protection controller acts on. Bytes come in one per clock while `byte_vld` is high, with the STS-1 slot changing fastest, then the column, then the row. A `frame_start` strobe that comes with a valid byte marks the first byte of a frame. Three counters follow the stream to find the overhead positions.

From the stream after the interchanger, the block takes both path-status bytes of every STS-1 slot. The two bytes carry the same information. It keeps the last value of each one. When a new capture differs from the kept value, the alarm bit for that slot is set and stays set. From the stream before the interchanger, it takes the line-status byte of one chosen slot in each group of slots and keeps it.

Software uses a small register port to read the kept bytes and the alarms, to clear alarms by writing ones, and to mask alarms away from the single interrupt line. Decisions about pointers and about switching belong to other logic.

Top module: `ohm_overhead_mon`

## Requirements
- R1: Byte order is slot fastest, then column, then row, with the row counting from 0 and wrapping after ROWS. A byte with `byte_vld` high and `frame_start` high is row 0, column 0, slot 0. A byte with `byte_vld` low does not move the position and captures nothing. A `frame_start` that comes with `byte_vld` low is ignored. Nothing is captured before the first valid `frame_start`.
- R2: On the post-interchanger stream, the first status byte of slot s sits at row 1, column 1. The second sits at row 1, column 2. Both rows and columns count from 0. Both bytes are kept per slot and read at address 2+s: bits 7:0 hold the first byte and bits 15:8 the second.
- R3: On the pre-interchanger stream, the line byte sits at row 8, column 2 of slot g*GRP+E2_SLOT for group g. It is kept per group, read at address 2+NSLOT+g in bits 7:0, and never raises an alarm.
- R4: For each slot, the first capture of each status byte after reset only loads the kept value and sets no alarm.
- R5: Any later capture of either status byte that differs from the kept value sets alarm bit s, read at address 0. A capture equal to the kept value leaves the alarm unchanged.
- R6: Alarm bits stay set until a write to address 0 with a 1 in that bit position. A 0 in the write data has no effect. If a new change arrives in the same cycle as the clear, the bit ends up set.
- R7: Address 1 holds the mask, read and write. A 1 in a mask bit keeps that alarm off `irq`, but the alarm still latches. `irq` is the OR of all alarm bits whose mask bit is 0.
- R8: `reg_rdata` shows the register at `reg_addr` one clock later. Unmapped addresses read 0. Writes to any address other than 0 and 1 change nothing.
- R9: After reset, alarms, mask, kept bytes, `reg_rdata` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Both stream bytes valid in this cycle |
| frame_start | input | 1 | This valid byte is the first of a frame |
| post_byte | input | 8 | Byte of the stream after the interchanger |
| pre_byte | input | 8 | Byte of the stream before the interchanger |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | OR of the unmasked alarms |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe with a defined address. They also assume that a new alarm bit can only come from a valid byte in the cycle before, so the checks rely on `byte_vld` being a clean level rather than on the frame counters. The stimulus holds `byte_vld` low for every register access between frames. Inside a frame, the only write it makes is the clear that lands on a capture cycle. Random idle cycles, some of them carrying an unqualified `frame_start`, only occur where the rule says they must be ignored.

// File: rtl/ohm_pkg.sv
package ohm_pkg;
  localparam int unsigned ADDR_ALARM      = 0;
  localparam int unsigned ADDR_MASK       = 1;
  localparam int unsigned ADDR_STORE_BASE = 2;
  localparam int unsigned OCTET_W         = 8;

  typedef logic [OCTET_W-1:0] octet_t;

  function automatic int unsigned cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ohm_frame_ctr.sv
module ohm_frame_ctr import ohm_pkg::*; #(
  parameter int unsigned ROWS  = 9,
  parameter int unsigned COLS  = 90,
  parameter int unsigned NSLOT = 12,
  localparam int unsigned RW = cw(ROWS),
  localparam int unsigned CW = cw(COLS),
  localparam int unsigned SW = cw(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          frame_start,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [SW-1:0] slot,
  output logic          pos_ok
);
  logic [RW-1:0] row_q, row_d, row_c;
  logic [CW-1:0] col_q, col_d, col_c;
  logic [SW-1:0] slot_q, slot_d, slot_c;
  logic          run_q, run_d;

  always_comb begin
    if (frame_start) begin
      row_c  = '0;
      col_c  = '0;
      slot_c = '0;
    end else begin
      row_c  = row_q;
      col_c  = col_q;
      slot_c = slot_q;
    end
    pos_ok = byte_vld && (frame_start || run_q);
    run_d  = run_q || (byte_vld && frame_start);
    row_d  = row_q;
    col_d  = col_q;
    slot_d = slot_q;
    if (pos_ok) begin
      row_d  = row_c;
      col_d  = col_c;
      if (slot_c == SW'(NSLOT-1)) begin
        slot_d = '0;
        if (col_c == CW'(COLS-1)) begin
          col_d = '0;
          if (row_c == RW'(ROWS-1)) row_d = '0;
          else                      row_d = row_c + 1'b1;
        end else begin
          col_d = col_c + 1'b1;
        end
      end else begin
        slot_d = slot_c + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      slot_q <= slot_d;
      run_q  <= run_d;
    end
  end

  assign row  = row_c;
  assign col  = col_c;
  assign slot = slot_c;
endmodule

// File: rtl/ohm_slot_track.sv
module ohm_slot_track import ohm_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cap_a,
  input  logic   cap_b,
  input  octet_t din,
  output octet_t a_q,
  output octet_t b_q,
  output logic   chg
);
  octet_t a_d, b_d;
  logic   a_seen_q, a_seen_d, b_seen_q, b_seen_d;

  always_comb begin
    a_d      = a_q;
    b_d      = b_q;
    a_seen_d = a_seen_q;
    b_seen_d = b_seen_q;
    if (cap_a) begin
      a_d      = din;
      a_seen_d = 1'b1;
    end
    if (cap_b) begin
      b_d      = din;
      b_seen_d = 1'b1;
    end
    chg = (cap_a && a_seen_q && (din != a_q)) ||
          (cap_b && b_seen_q && (din != b_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      a_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else begin
      a_q      <= a_d;
      b_q      <= b_d;
      a_seen_q <= a_seen_d;
      b_seen_q <= b_seen_d;
    end
  end
endmodule

// File: rtl/ohm_grp_cap.sv
module ohm_grp_cap import ohm_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cap,
  input  octet_t din,
  output octet_t val_q
);
  octet_t val_d;

  always_comb begin
    val_d = val_q;
    if (cap) val_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end
endmodule

// File: rtl/ohm_overhead_mon.sv
module ohm_overhead_mon import ohm_pkg::*; #(
  parameter int unsigned NSLOT  = 12,
  parameter int unsigned GRP    = 12,
  parameter int unsigned ROWS   = 9,
  parameter int unsigned COLS   = 90,
  parameter int unsigned AW     = 6,
  parameter int unsigned DW     = 16,
  parameter int unsigned E1_ROW = 1,
  parameter int unsigned E1_COL = 1,
  parameter int unsigned F1_ROW = 1,
  parameter int unsigned F1_COL = 2,
  parameter int unsigned E2_ROW = 8,
  parameter int unsigned E2_COL = 2,
  parameter int unsigned E2_SLOT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          frame_start,
  input  logic [7:0]    post_byte,
  input  logic [7:0]    pre_byte,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int unsigned NGRP    = NSLOT / GRP;
  localparam int unsigned E2_BASE = ADDR_STORE_BASE + NSLOT;
  localparam int unsigned RW      = cw(ROWS);
  localparam int unsigned CW      = cw(COLS);
  localparam int unsigned SW      = cw(NSLOT);

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [SW-1:0] slot;
  logic          pos_ok;

  logic [NSLOT-1:0][7:0] e1_st, f1_st;
  logic [NGRP-1:0][7:0]  e2_st;
  logic [NSLOT-1:0]      alm_set, alm_clr;
  logic [NSLOT-1:0]      alarm_q, alarm_d, mask_q, mask_d;
  logic [DW-1:0]         rd_d;

  ohm_frame_ctr #(.ROWS(ROWS), .COLS(COLS), .NSLOT(NSLOT)) u_pos (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_start(frame_start),
    .row(row), .col(col), .slot(slot), .pos_ok(pos_ok)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit_a, hit_b;
    assign hit_a = pos_ok && (row == RW'(E1_ROW)) && (col == CW'(E1_COL)) &&
                   (slot == SW'(s));
    assign hit_b = pos_ok && (row == RW'(F1_ROW)) && (col == CW'(F1_COL)) &&
                   (slot == SW'(s));
    ohm_slot_track u_trk (
      .clk(clk), .rst_n(rst_n), .cap_a(hit_a), .cap_b(hit_b), .din(post_byte),
      .a_q(e1_st[s]), .b_q(f1_st[s]), .chg(alm_set[s])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit_e2;
    assign hit_e2 = pos_ok && (row == RW'(E2_ROW)) && (col == CW'(E2_COL)) &&
                    (slot == SW'(g*GRP + E2_SLOT));
    ohm_grp_cap u_cap (
      .clk(clk), .rst_n(rst_n), .cap(hit_e2), .din(pre_byte), .val_q(e2_st[g])
    );
  end

  always_comb begin
    alm_clr = '0;
    mask_d  = mask_q;
    if (reg_wr && (reg_addr == AW'(ADDR_ALARM))) alm_clr = reg_wdata[NSLOT-1:0];
    if (reg_wr && (reg_addr == AW'(ADDR_MASK)))  mask_d  = reg_wdata[NSLOT-1:0];
    alarm_d = (alarm_q & ~alm_clr) | alm_set;
  end

  always_comb begin
    rd_d = '0;
    if (reg_addr == AW'(ADDR_ALARM)) rd_d[NSLOT-1:0] = alarm_q;
    if (reg_addr == AW'(ADDR_MASK))  rd_d[NSLOT-1:0] = mask_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (reg_addr == AW'(ADDR_STORE_BASE + s)) rd_d[15:0] = {f1_st[s], e1_st[s]};
    end
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == AW'(E2_BASE + g)) rd_d[7:0] = e2_st[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q   <= '0;
      mask_q    <= '0;
      reg_rdata <= '0;
    end else begin
      alarm_q   <= alarm_d;
      mask_q    <= mask_d;
      reg_rdata <= rd_d;
    end
  end

  assign irq = |(alarm_q & ~mask_q);
endmodule

// File: rtl/ohm_overhead_mon_chk.sv
module ohm_overhead_mon_chk #(
  parameter int unsigned NSLOT   = 12,
  parameter int unsigned AW      = 6,
  parameter int unsigned DW      = 16,
  parameter int unsigned MAP_END = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_wr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             irq,
  input logic [NSLOT-1:0] alarm_q
);
  // R6: an alarm bit only drops after a write of 1 to that bit at address 0
  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(alarm_q) & ~alarm_q &
      ~(($past(reg_wr) && ($past(reg_addr) == AW'(0))) ?
        $past(reg_wdata[NSLOT-1:0]) : {NSLOT{1'b0}})) == {NSLOT{1'b0}}));

  // R5: a new alarm bit needs a valid stream byte in the cycle before
  a_r5_alarm_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ((alarm_q & ~$past(alarm_q)) != {NSLOT{1'b0}}) |-> $past(byte_vld));

  // R7: writing an all-ones mask silences the interrupt
  a_r7_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && ($past(reg_addr) == AW'(1)) && (&$past(reg_wdata[NSLOT-1:0])))
    |-> !irq);

  // R8: unmapped addresses read zero one cycle later
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) >= AW'(MAP_END)) |-> (reg_rdata == '0));
endmodule

bind ohm_overhead_mon ohm_overhead_mon_chk #(
  .NSLOT(NSLOT), .AW(AW), .DW(DW), .MAP_END(E2_BASE + NGRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .alarm_q(alarm_q)
);

// File: tb/sim_ohm_overhead_mon.sv
module sim_ohm_overhead_mon;
  localparam int NSLOT = 12, GRP = 4, NGRP = 3, ROWS = 9, COLS = 4;
  localparam int AW = 6, DW = 16;
  localparam int E2B = 2 + NSLOT, MAPEND = E2B + NGRP;

  logic clk, rst_n, byte_vld, frame_start, reg_wr, irq;
  logic [7:0] post_byte, pre_byte;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  ohm_overhead_mon #(.NSLOT(NSLOT), .GRP(GRP), .ROWS(ROWS), .COLS(COLS),
                     .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_start(frame_start),
    .post_byte(post_byte), .pre_byte(pre_byte), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned seed_dummy;

  logic [7:0] m_e1 [NSLOT];
  logic [7:0] m_f1 [NSLOT];
  bit         m_s1 [NSLOT];
  bit         m_s2 [NSLOT];
  logic [7:0] m_e2 [NGRP];
  logic [NSLOT-1:0] m_alarm, m_mask;
  logic [7:0] fe1 [NSLOT];
  logic [7:0] ff1 [NSLOT];
  logic [7:0] fe2 [NGRP];

  function automatic logic [DW-1:0] exp_reg(input int a);
    if (a == 0) return {{(DW-NSLOT){1'b0}}, m_alarm};
    if (a == 1) return {{(DW-NSLOT){1'b0}}, m_mask};
    if (a >= 2 && a < E2B) return {m_f1[a-2], m_e1[a-2]};
    if (a >= E2B && a < MAPEND) return {8'h00, m_e2[a-E2B]};
    return '0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R6";
    if (a == 1) return "R7";
    if (a < E2B) return "R2";
    if (a < MAPEND) return "R3";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    byte_vld = 0; reg_wr = 0; reg_addr = AW'(a);
    @(negedge clk);
    check(tag, {16'h0, reg_rdata}, {16'h0, exp_reg(a)});
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    byte_vld = 0; reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) m_alarm = m_alarm & ~d[NSLOT-1:0];
    if (a == 1) m_mask = d[NSLOT-1:0];
  endtask

  task automatic check_all(input string pre);
    for (int a = 0; a < MAPEND + 2; a++) rd_chk(a, {pre, " ", tag_of(a)});
    check({pre, " R7 irq"}, {31'h0, irq}, {31'h0, |(m_alarm & ~m_mask)});
  endtask

  task automatic pick(input int mode);
    for (int s = 0; s < NSLOT; s++) begin
      if (mode == 0) begin
        fe1[s] = 8'($urandom); ff1[s] = 8'($urandom);
      end else begin
        fe1[s] = m_e1[s]; ff1[s] = m_f1[s];
        if (mode == 2) begin
          int unsigned k = $urandom % 3;
          if (k == 1) fe1[s] = m_e1[s] ^ 8'(1 + $urandom % 255);
          if (k == 2) ff1[s] = m_f1[s] ^ 8'(1 + $urandom % 255);
        end
      end
    end
    for (int g = 0; g < NGRP; g++) fe2[g] = 8'($urandom);
  endtask

  // R1: slot fastest, then column, then row; gaps and unqualified frame_start ignored
  task automatic send_frame(input int clr_slot, input logic [NSLOT-1:0] clr_bits);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int s = 0; s < NSLOT; s++) begin
          bit is_e1, is_f1, is_e2, do_clr;
          logic [NSLOT-1:0] setv, clrv;
          if ($urandom % 4 == 0) begin
            @(negedge clk);
            byte_vld = 0; reg_wr = 0; frame_start = 1'($urandom);
            post_byte = 8'($urandom); pre_byte = 8'($urandom);
          end
          is_e1 = (r == 1 && c == 1);
          is_f1 = (r == 1 && c == 2);
          is_e2 = (r == 8 && c == 2 && (s % GRP == 0));
          do_clr = is_e1 && (s == clr_slot);
          @(negedge clk);
          byte_vld = 1;
          frame_start = (r == 0 && c == 0 && s == 0);
          post_byte = is_e1 ? fe1[s] : is_f1 ? ff1[s] : 8'($urandom);
          pre_byte = is_e2 ? fe2[s/GRP] : 8'($urandom);
          reg_wr = do_clr; reg_addr = '0; reg_wdata = {{(DW-NSLOT){1'b0}}, clr_bits};
          setv = '0;
          if (is_e1) begin
            if (m_s1[s] && m_e1[s] != fe1[s]) setv[s] = 1'b1;
            m_e1[s] = fe1[s]; m_s1[s] = 1;
          end
          if (is_f1) begin
            if (m_s2[s] && m_f1[s] != ff1[s]) setv[s] = 1'b1;
            m_f1[s] = ff1[s]; m_s2[s] = 1;
          end
          if (is_e2) m_e2[s/GRP] = fe2[s/GRP];
          clrv = do_clr ? clr_bits : '0;
          m_alarm = (m_alarm & ~clrv) | setv;
        end
    @(negedge clk);
    byte_vld = 0; reg_wr = 0; frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_0C4A);
    rst_n = 0; byte_vld = 0; frame_start = 0; reg_wr = 0;
    post_byte = 0; pre_byte = 0; reg_addr = 0; reg_wdata = 0;
    m_alarm = '0; m_mask = '0;
    for (int s = 0; s < NSLOT; s++) begin m_e1[s] = 0; m_f1[s] = 0; m_s1[s] = 0; m_s2[s] = 0; end
    for (int g = 0; g < NGRP; g++) m_e2[g] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 rdata in reset", {16'h0, reg_rdata}, 32'h0);
    check("R9 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1;
    check_all("R9 after reset");

    // R1: a full frame of valid bytes with no frame_start captures nothing
    for (int i = 0; i < ROWS*COLS*NSLOT; i++) begin
      @(negedge clk);
      byte_vld = 1; frame_start = 0;
      post_byte = 8'(1 + $urandom % 255); pre_byte = 8'(1 + $urandom % 255);
    end
    @(negedge clk);
    byte_vld = 0; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    check_all("R1 unsynced");

    // R4: first capture loads, no alarm
    pick(0); send_frame(-1, '0);
    check_all("R4 first frame");
    check("R4 no alarm", {20'h0, m_alarm}, 32'h0);

    // R5: identical bytes raise nothing
    pick(1); send_frame(-1, '0);
    check_all("R5 repeat");

    // R5: changed bytes latch
    pick(2); send_frame(-1, '0);
    check_all("R5 change");

    // R7: mask
    wr(1, DW'($urandom));
    check_all("R7 mask");
    wr(1, 16'h0000);
    // R6: partial clear, then zero write
    wr(0, DW'($urandom));
    check_all("R6 partial clear");
    wr(0, 16'h0000);
    check_all("R6 zero write");

    // R6: set and clear in the same cycle, slot 5 cleared without change
    pick(1);
    fe1[5] = m_e1[5] ^ 8'h5A; ff1[5] = fe1[5] ^ 8'h01;
    send_frame(-1, '0);
    pick(1);
    fe1[3] = m_e1[3] ^ 8'h81;
    send_frame(3, 12'h028);
    rd_chk(0, "R6 same-cycle");
    check("R6 change beats clear", {31'h0, m_alarm[3]}, 32'h1);
    check("R6 bit5 cleared", {31'h0, m_alarm[5]}, 32'h0);

    // R8: writes elsewhere are ignored
    wr(2 + 5, 16'hFFFF);
    wr(E2B, 16'hFFFF);
    wr(MAPEND + 3, 16'hFFFF);
    check_all("R8 ignored writes");

    for (int it = 0; it < 8; it++) begin
      int cs;
      cs = ($urandom % 2 == 0) ? int'($urandom % NSLOT) : -1;
      pick(int'($urandom % 3));
      send_frame(cs, NSLOT'($urandom));
      if ($urandom % 2 == 0) wr(1, DW'($urandom));
      if ($urandom % 2 == 0) wr(0, DW'($urandom));
      check_all("R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule